// File: doc/BRIEF.md
# Shared Address/Data Bus Splitter and Command Decoder

This block sits between a processor core whose low address byte and data byte share one set of pins and the external memory and I/O devices. During the first part of each bus cycle the core drives the low address byte on the shared lines and raises an address strobe. The block passes that byte through while the strobe is high. When the strobe drops, the block holds the byte and joins it with the separate, output-only high address byte to form a steady 16-bit address covering 0000h to FFFFh.

The core signals a transfer with active-low read and write lines and a space select (0 = memory, 1 = I/O). The block turns these into four separate active-low commands: memory read, memory write, I/O read and I/O write. Read and write low together is illegal. In that case no command is issued and an error flag is raised. The block also steers the data phase. Write data from the shared lines goes out toward the devices. During a read, device data is driven back onto the shared lines. Each driver is enabled only in its own data phase and only while the address strobe is low.

Top module: `ad_bus_splitter`

## Requirements
- R1: Reset (`rst_n` low) clears the held low address byte to 00h. With `ale` low after reset, `addr` reads `{a_hi, 8'h00}`.
- R2: While `ale` is 1, `addr[7:0]` equals `ad_in` in the same cycle.
- R3: While `ale` is 0, `addr[7:0]` keeps the value `ad_in` had at the last rising clock edge where `ale` was 1. Changes on `ad_in` have no effect on it.
- R4: `addr[15:8]` always equals `a_hi`.
- R5: `memr_n` is 0 exactly when `rd_n`=0, `wr_n`=1 and `io_m`=0.
- R6: `ior_n` is 0 exactly when `rd_n`=0, `wr_n`=1 and `io_m`=1.
- R7: `memw_n` is 0 exactly when `wr_n`=0, `rd_n`=1 and `io_m`=0.
- R8: `iow_n` is 0 exactly when `wr_n`=0, `rd_n`=1 and `io_m`=1.
- R9: When `rd_n` and `wr_n` are both 0, all four commands stay 1 and `bus_err` is 1. Otherwise `bus_err` is 0. At most one command is 0 at any time.
- R10: `wdata_oe` is 1 exactly when `memw_n` or `iow_n` is 0 and `ale` is 0, and `wdata` equals `ad_in`.
- R11: `ad_oe` is 1 exactly when `memr_n` or `ior_n` is 0 and `ale` is 0, and `ad_out` equals `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address strobe, high while the shared lines carry the low address |
| ad_in | input | 8 | Shared address/data lines as driven by the core |
| a_hi | input | 8 | High address byte |
| rd_n | input | 1 | Read request, active low |
| wr_n | input | 1 | Write request, active low |
| io_m | input | 1 | Space select, 0 memory, 1 I/O |
| rdata | input | 8 | Read data returned by the selected device |
| addr | output | 16 | Demultiplexed full address |
| memr_n | output | 1 | Memory read command, active low |
| memw_n | output | 1 | Memory write command, active low |
| ior_n | output | 1 | I/O read command, active low |
| iow_n | output | 1 | I/O write command, active low |
| bus_err | output | 1 | Read and write requested together |
| wdata | output | 8 | Write data toward the devices |
| wdata_oe | output | 1 | Enable for the write data driver |
| ad_out | output | 8 | Read data toward the shared lines |
| ad_oe | output | 1 | Enable for the shared-line driver |

## Verification
The decoder is driven with all eight combinations of read, write and space select, both in directed form and many times over in random order. This separates each of the four commands from the other three and from the illegal both-low case. Address capture is tested with random changes on the shared lines during and after the strobe. This distinguishes a transparent latch from one that samples at the wrong edge or keeps following the bus. Random strobe levels during data phases confirm that neither driver turns on while the address strobe is high.

// File: rtl/ad_bus_pkg.sv
package ad_bus_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE    = 3'd0,
    CYC_MEMR    = 3'd1,
    CYC_MEMW    = 3'd2,
    CYC_IOR     = 3'd3,
    CYC_IOW     = 3'd4,
    CYC_ILLEGAL = 3'd5
  } cyc_e;

  typedef struct packed {
    logic memr_n;
    logic memw_n;
    logic ior_n;
    logic iow_n;
  } cmd_t;

  localparam cmd_t CMD_IDLE = '{memr_n: 1'b1, memw_n: 1'b1, ior_n: 1'b1, iow_n: 1'b1};
endpackage

// File: rtl/ad_lo_latch.sv
module ad_lo_latch #(
  parameter int LO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale,
  input  logic [LO_W-1:0] ad_in,
  output logic [LO_W-1:0] lo_addr
);
  logic [LO_W-1:0] held_q;

  // capture every edge the strobe is high; last capture survives the fall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held_q <= '0;
    else if (ale) held_q <= ad_in;
  end

  // transparent path while the strobe is high
  always_comb lo_addr = ale ? ad_in : held_q;
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import ad_bus_pkg::*;
(
  input  logic rd_n,
  input  logic wr_n,
  input  logic io_m,
  output cyc_e cyc,
  output cmd_t cmd
);
  always_comb begin
    unique case ({rd_n, wr_n, io_m})
      3'b000, 3'b001: cyc = CYC_ILLEGAL;
      3'b010:         cyc = CYC_MEMR;
      3'b011:         cyc = CYC_IOR;
      3'b100:         cyc = CYC_MEMW;
      3'b101:         cyc = CYC_IOW;
      default:        cyc = CYC_IDLE;
    endcase
  end

  always_comb begin
    cmd = CMD_IDLE;
    case (cyc)
      CYC_MEMR: cmd.memr_n = 1'b0;
      CYC_MEMW: cmd.memw_n = 1'b0;
      CYC_IOR:  cmd.ior_n  = 1'b0;
      CYC_IOW:  cmd.iow_n  = 1'b0;
      default:  cmd = CMD_IDLE;
    endcase
  end
endmodule

// File: rtl/data_steer.sv
module data_steer
  import ad_bus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  cyc_e              cyc,
  input  logic              ale,
  input  logic [DATA_W-1:0] ad_in,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] wdata,
  output logic              wdata_oe,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe
);
  logic is_wr, is_rd;

  always_comb begin
    is_wr    = (cyc == CYC_MEMW) || (cyc == CYC_IOW);
    is_rd    = (cyc == CYC_MEMR) || (cyc == CYC_IOR);
    wdata    = ad_in;
    ad_out   = rdata;
    wdata_oe = is_wr && !ale;
    ad_oe    = is_rd && !ale;
  end
endmodule

// File: rtl/ad_bus_splitter.sv
module ad_bus_splitter
  import ad_bus_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 8,
  localparam int ADDR_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic [LO_W-1:0]   ad_in,
  input  logic [HI_W-1:0]   a_hi,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              io_m,
  input  logic [LO_W-1:0]   rdata,
  output logic [ADDR_W-1:0] addr,
  output logic              memr_n,
  output logic              memw_n,
  output logic              ior_n,
  output logic              iow_n,
  output logic              bus_err,
  output logic [LO_W-1:0]   wdata,
  output logic              wdata_oe,
  output logic [LO_W-1:0]   ad_out,
  output logic              ad_oe
);
  logic [LO_W-1:0] lo_addr;
  cyc_e            cyc;
  cmd_t            cmd;

  ad_lo_latch #(.LO_W(LO_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in), .lo_addr(lo_addr)
  );

  cmd_decode u_dec (
    .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .cyc(cyc), .cmd(cmd)
  );

  data_steer #(.DATA_W(LO_W)) u_steer (
    .cyc(cyc), .ale(ale), .ad_in(ad_in), .rdata(rdata),
    .wdata(wdata), .wdata_oe(wdata_oe), .ad_out(ad_out), .ad_oe(ad_oe)
  );

  always_comb begin
    addr    = {a_hi, lo_addr};
    memr_n  = cmd.memr_n;
    memw_n  = cmd.memw_n;
    ior_n   = cmd.ior_n;
    iow_n   = cmd.iow_n;
    bus_err = (cyc == CYC_ILLEGAL);
  end
endmodule

// File: rtl/ad_bus_splitter_chk.sv
module ad_bus_splitter_chk #(
  parameter int LO_W = 8,
  parameter int HI_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ale,
  input logic [HI_W-1:0]      a_hi,
  input logic                 rd_n,
  input logic                 wr_n,
  input logic                 io_m,
  input logic [LO_W+HI_W-1:0] addr,
  input logic                 memr_n,
  input logic                 memw_n,
  input logic                 ior_n,
  input logic                 iow_n,
  input logic                 bus_err,
  input logic                 wdata_oe,
  input logic                 ad_oe
);
  logic seen_edge;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_edge <= 1'b0;
    else        seen_edge <= 1'b1;
  end

  AST_HI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    addr[LO_W+HI_W-1:LO_W] == a_hi); // R4
  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && !ale && !$past(ale)) |-> $stable(addr[LO_W-1:0])); // R3
  AST_MEMR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !memr_n |-> (!rd_n && wr_n && !io_m)); // R5
  AST_IOW_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !iow_n |-> (!wr_n && rd_n && io_m)); // R8
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({memr_n, memw_n, ior_n, iow_n}) >= 3); // R9
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (memr_n && memw_n && ior_n && iow_n && !rd_n && !wr_n)); // R9
  AST_WOE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_oe |-> (!ale && (!memw_n || !iow_n))); // R10
  AST_ROE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!ale && (!memr_n || !ior_n) && !wdata_oe)); // R11
endmodule

bind ad_bus_splitter ad_bus_splitter_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .a_hi(a_hi), .rd_n(rd_n), .wr_n(wr_n),
  .io_m(io_m), .addr(addr), .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n),
  .iow_n(iow_n), .bus_err(bus_err), .wdata_oe(wdata_oe), .ad_oe(ad_oe)
);

// File: tb/ad_bus_splitter_bench.sv
`timescale 1ns/1ps
module ad_bus_splitter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale = 1'b0;
  logic [7:0]  ad_in = 8'h00, a_hi = 8'h00, rdata = 8'h00;
  logic        rd_n = 1'b1, wr_n = 1'b1, io_m = 1'b0;
  logic [15:0] addr;
  logic        memr_n, memw_n, ior_n, iow_n, bus_err, wdata_oe, ad_oe;
  logic [7:0]  wdata, ad_out;

  int checks = 0, failures = 0;
  logic [7:0] held = 8'h00;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ad_bus_splitter u_ad_bus_splitter (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in), .a_hi(a_hi),
    .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .rdata(rdata), .addr(addr),
    .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
    .bus_err(bus_err), .wdata(wdata), .wdata_oe(wdata_oe),
    .ad_out(ad_out), .ad_oe(ad_oe)
  );

  // expected command vector {memr_n, memw_n, ior_n, iow_n}
  function automatic logic [3:0] exp_cmd(logic r, logic w, logic io);
    logic [3:0] v = 4'b1111;
    if (!r && w)  v = io ? 4'b1101 : 4'b0111;
    if (r && !w)  v = io ? 4'b1110 : 4'b1011;
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [3:0] c = exp_cmd(rd_n, wr_n, io_m);
    logic [3:0] a = {memr_n, memw_n, ior_n, iow_n};
    chk("R4", addr[15:8], a_hi);
    if (ale) chk("R2", addr[7:0], ad_in);
    else     chk("R3", addr[7:0], held);
    chk("R5", a[3], c[3]);
    chk("R7", a[2], c[2]);
    chk("R6", a[1], c[1]);
    chk("R8", a[0], c[0]);
    chk("R9", bus_err, (!rd_n && !wr_n));
    chk("R10", wdata_oe, (!ale && (c[2] == 1'b0 || c[0] == 1'b0)));
    chk("R10", wdata, ad_in);
    chk("R11", ad_oe, (!ale && (c[3] == 1'b0 || c[1] == 1'b0)));
    chk("R11", ad_out, rdata);
  endtask

  task automatic step(logic l, logic [7:0] ad, logic [7:0] hi,
                      logic r, logic w, logic io, logic [7:0] rd);
    @(negedge clk);
    ale = l; ad_in = ad; a_hi = hi; rd_n = r; wr_n = w; io_m = io; rdata = rd;
    #4;
    check_all();
    @(posedge clk);
    if (ale) held = ad_in;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7351));
    a_hi = 8'h12;
    repeat (3) @(posedge clk);
    #4;
    chk("R1", addr, 16'h1200);
    @(negedge clk);
    rst_n = 1'b1;
    #4;
    chk("R1", addr, 16'h1200);

    // directed: memory write cycle, bus changes after strobe falls
    step(1'b1, 8'hA5, 8'h3C, 1'b1, 1'b1, 1'b0, 8'h00);
    step(1'b0, 8'h5E, 8'h3C, 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R3", addr, 16'h3CA5);
    step(1'b0, 8'h77, 8'h3C, 1'b1, 1'b0, 1'b0, 8'h00);
    // directed: all eight decode combinations
    for (int k = 0; k < 8; k++)
      step(1'b0, 8'h11, 8'h40, k[2], k[1], k[0], 8'hC3);
    // directed: illegal request while strobe high
    step(1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 8'h9A);
    step(1'b0, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h9A);
    chk("R9", {memr_n, memw_n, ior_n, iow_n}, 4'hF);
    // directed: read driver held off while strobe high
    step(1'b1, 8'h20, 8'h80, 1'b0, 1'b1, 1'b1, 8'h6B);
    step(1'b0, 8'h99, 8'h80, 1'b0, 1'b1, 1'b1, 8'h6B);

    // random phase: strobe high one quarter of the time, illegal rarely
    for (int i = 0; i < 2000; i++) begin
      logic r, w;
      int sel = $urandom_range(0, 15);
      r = (sel < 6) ? 1'b0 : (sel < 12) ? 1'b1 : $urandom_range(0, 1) == 0;
      w = (sel < 6) ? 1'b1 : (sel < 12) ? 1'b0 : $urandom_range(0, 1) == 0;
      step($urandom_range(0, 3) == 0, 8'($urandom), 8'($urandom),
           r, w, 1'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule